// File: doc/BRIEF.md
# Receive Transport Deframer for a Multi-Lane Serial Converter Link

This block sits between the link layer of a multi-lane serial converter link and the application logic that consumes converter samples. On every link clock it takes one 32-bit word from each lane and rebuilds, for every converter, a beat of DPW samples. Each 32-bit lane word holds 32/(8F) whole frames, and the frames are unpacked in the order they were sent. The block undoes exactly the octet and converter placement of the matching transmit framer, so a loopback returns the original samples.

The mapping is set by six parameters: lane count L, converter count M, samples per converter per frame S, container bits per sample NP, converter resolution N and octets per lane per frame F. Only F of 1, 2 or 4 and NP of 8 or 16 are accepted. The set must satisfy M*S*NP = L*F*8, and DPW = L*32/(M*NP) must be a whole number. A configuration that breaks any of these rules stops elaboration. When N is smaller than NP, each sample is shortened to its N most significant bits.

A single register stage turns the lane words into samples. Output valid is the input valid delayed by one clock. While valid is low, the sample outputs keep their last value.

Top module: `jrx_deframer`

## Requirements
- R1: While rst_n is low, and on the first clock after it, smp_valid_o is 0 and every bit of smp_data_o is 0.
- R2: smp_valid_o equals lane_valid_i from the previous rising clock edge, with exactly one clock of latency.
- R3: In each lane word, the octet at bits [8k+7:8k] is the k-th in time. Frame j of the word uses that lane's octets jF to jF+F-1. The samples of frame j become output sample indices j*S to j*S+S-1 of each converter.
- R4: Within one frame, the link octets are numbered lane by lane, so lane l carries frame octets lF to lF+F-1. The samples are laid out MSB first, converter-major then sample-minor: converter c, sample s starts at bit (c*S+s)*NP, counted from the first bit of frame octet 0.
- R5: Only the N most significant bits of each NP-bit sample reach the output. The NP-N tail bits have no effect on smp_data_o.
- R6: When lane_valid_i is low at a clock edge, smp_data_o keeps its previous value, whatever lane_data_i carries.
- R7: Converter c, sample index d (0 to DPW-1) is presented at smp_data_o[(c*DPW+d)*N +: N].
- R8: DPW equals L*32/(M*NP), and smp_data_o is M*DPW*N bits wide. Any F outside {1,2,4}, any NP outside {8,16}, N greater than NP, or a set that breaks M*S*NP = L*F*8 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data_i | input | L*32 | Lane words, lane l at bits [32l+31:32l] |
| lane_valid_i | input | 1 | Lane words are valid this cycle |
| smp_data_o | output | M*DPW*N | Rebuilt samples, packed as in R7 |
| smp_valid_o | output | 1 | Sample beat is valid |

## Verification
Two functions can act in the same cycle: fresh lane words arriving and the valid-driven hold of the sample register. The bench provokes this by driving new random lane data while valid is low. It judges the cycle by requiring the outputs to match the last valid beat, not the new data. Tail truncation and reassembly also meet in every beat. The bench finds the tail positions by probing single lane bits, then flips those bits in random words and requires the output to match the unflipped word.

// File: rtl/jrx_pkg.sv
`timescale 1ns/1ps
package jrx_pkg;
    localparam int unsigned LANE_W = 32;
    localparam int unsigned OCT_W  = 8;

    // frames carried in one lane word
    function automatic int unsigned frames_per_word(input int unsigned f);
        return (LANE_W / OCT_W) / f;
    endfunction

    // samples per converter per clock
    function automatic int unsigned beat_depth(input int unsigned l, input int unsigned m,
                                               input int unsigned np);
        return (l * LANE_W) / (m * np);
    endfunction

    function automatic bit cfg_ok(input int unsigned l, input int unsigned m,
                                  input int unsigned s, input int unsigned np,
                                  input int unsigned n, input int unsigned f);
        bit ok;
        ok = (l >= 1) && (m >= 1) && (s >= 1) && (n >= 1);
        ok = ok && (f == 1 || f == 2 || f == 4);
        ok = ok && (np == 8 || np == 16);
        ok = ok && (n <= np);
        ok = ok && (m * s * np == l * f * OCT_W);
        ok = ok && ((l * LANE_W) % (m * np) == 0);
        return ok;
    endfunction
endpackage

// File: rtl/jrx_cfg_check.sv
`timescale 1ns/1ps
module jrx_cfg_check #(
    parameter int unsigned L  = 2,
    parameter int unsigned M  = 2,
    parameter int unsigned S  = 1,
    parameter int unsigned NP = 16,
    parameter int unsigned N  = 14,
    parameter int unsigned F  = 2
) ();
    // R8: reject illegal link parameter sets at elaboration
    generate
        if (!jrx_pkg::cfg_ok(L, M, S, NP, N, F)) begin : g_bad_cfg
            $error("jrx_cfg_check: illegal deframer parameter set");
        end
    endgenerate
endmodule

// File: rtl/jrx_lane_unpack.sv
`timescale 1ns/1ps
module jrx_lane_unpack #(
    parameter int unsigned L = 2,
    parameter int unsigned F = 2
) (
    input  logic [L*jrx_pkg::LANE_W-1:0]                          lanes_i,
    output logic [jrx_pkg::frames_per_word(F)*L*F*jrx_pkg::OCT_W-1:0] frames_o
);
    localparam int unsigned OW  = jrx_pkg::OCT_W;
    localparam int unsigned LW  = jrx_pkg::LANE_W;
    localparam int unsigned FPW = jrx_pkg::frames_per_word(F);
    localparam int unsigned FB  = L * F * OW;

    // Frame j occupies [j*FB +: FB]; frame octet 0 sits at the top (MSB first).
    // R3: lane octet k is k-th in time; R4: lane l holds frame octets l*F..l*F+F-1
    for (genvar j = 0; j < FPW; j++) begin : g_frame
        for (genvar l = 0; l < L; l++) begin : g_lane
            for (genvar o = 0; o < F; o++) begin : g_oct
                localparam int unsigned FOCT = l * F + o;
                localparam int unsigned DST  = j * FB + FB - (FOCT + 1) * OW;
                localparam int unsigned SRC  = l * LW + (j * F + o) * OW;
                assign frames_o[DST +: OW] = lanes_i[SRC +: OW];
            end
        end
    end
endmodule

// File: rtl/jrx_sample_split.sv
`timescale 1ns/1ps
module jrx_sample_split #(
    parameter int unsigned L  = 2,
    parameter int unsigned M  = 2,
    parameter int unsigned S  = 1,
    parameter int unsigned NP = 16,
    parameter int unsigned N  = 14,
    parameter int unsigned F  = 2
) (
    input  logic [jrx_pkg::frames_per_word(F)*L*F*jrx_pkg::OCT_W-1:0] frames_i,
    output logic [M*jrx_pkg::beat_depth(L, M, NP)*N-1:0]              samples_o
);
    localparam int unsigned FPW = jrx_pkg::frames_per_word(F);
    localparam int unsigned FB  = L * F * jrx_pkg::OCT_W;
    localparam int unsigned DPW = jrx_pkg::beat_depth(L, M, NP);

    // R4/R5/R7: slice each sample MSB-first, keep its top N bits
    for (genvar c = 0; c < M; c++) begin : g_conv
        for (genvar j = 0; j < FPW; j++) begin : g_frame
            for (genvar s = 0; s < S; s++) begin : g_smp
                localparam int unsigned TOP = j * FB + FB - 1 - (c * S + s) * NP;
                localparam int unsigned IDX = c * DPW + j * S + s;
                assign samples_o[IDX*N +: N] = frames_i[TOP -: N];
            end
        end
    end

    // tail bits are dropped on purpose
    logic unused_tail;
    assign unused_tail = ^frames_i;
endmodule

// File: rtl/jrx_deframer.sv
`timescale 1ns/1ps
module jrx_deframer #(
    parameter int unsigned L  = 2,
    parameter int unsigned M  = 2,
    parameter int unsigned S  = 1,
    parameter int unsigned NP = 16,
    parameter int unsigned N  = 14,
    parameter int unsigned F  = 2,
    localparam int unsigned DPW   = jrx_pkg::beat_depth(L, M, NP),
    localparam int unsigned IN_W  = L * jrx_pkg::LANE_W,
    localparam int unsigned OUT_W = M * DPW * N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  lane_data_i,
    input  logic             lane_valid_i,
    output logic [OUT_W-1:0] smp_data_o,
    output logic             smp_valid_o
);
    localparam int unsigned FW = jrx_pkg::frames_per_word(F) * L * F * jrx_pkg::OCT_W;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] smp;
    } st_t;

    st_t              st_d, st_q;
    logic [FW-1:0]    frames;
    logic [OUT_W-1:0] smp_comb;

    jrx_cfg_check #(.L(L), .M(M), .S(S), .NP(NP), .N(N), .F(F)) u_chk ();

    jrx_lane_unpack #(.L(L), .F(F)) u_unpack (
        .lanes_i  (lane_data_i),
        .frames_o (frames)
    );

    jrx_sample_split #(.L(L), .M(M), .S(S), .NP(NP), .N(N), .F(F)) u_split (
        .frames_i  (frames),
        .samples_o (smp_comb)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = lane_valid_i;
        if (lane_valid_i) begin
            st_d.smp = smp_comb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_data_o  = st_q.smp;
    assign smp_valid_o = st_q.vld;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!smp_valid_o && smp_data_o == '0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid_i |=> smp_valid_o);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_valid_i |=> !smp_valid_o);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_valid_i |=> $stable(smp_data_o));
endmodule

// File: tb/tb_jrx_deframer.sv
`timescale 1ns/1ps
module tb_jrx_deframer;
    localparam int L = 2, M = 2, S = 1, NP = 16, N = 14, F = 2;
    localparam int DPW = (L * 32) / (M * NP);
    localparam int IW  = L * 32;
    localparam int OW  = M * DPW * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] lane_data = '0;
    logic          lane_valid = 1'b0;
    logic [OW-1:0] smp_data;
    logic          smp_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    jrx_deframer #(.L(L), .M(M), .S(S), .NP(NP), .N(N), .F(F)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_data_i  (lane_data),
        .lane_valid_i (lane_valid),
        .smp_data_o   (smp_data),
        .smp_valid_o  (smp_valid)
    );

    // expected beat computed octet by octet from the requirement text
    function automatic logic [OW-1:0] model(input logic [IW-1:0] w);
        logic [OW-1:0] r = '0;
        for (int c = 0; c < M; c++) begin
            for (int d = 0; d < DPW; d++) begin
                int j = d / S;
                int s = d % S;
                int b = (c * S + s) * NP;
                logic [NP-1:0] v = '0;
                for (int k = 0; k < NP / 8; k++) begin
                    int o   = b / 8 + k;
                    int l   = o / F;
                    int pos = j * F + (o % F);
                    v = (v << 8) | NP'(w[l*32 + pos*8 +: 8]);
                end
                r[(c*DPW + d)*N +: N] = v[NP-1 -: N];
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [OW-1:0] act,
                         input logic [OW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [OW-1:0] last_beat = '0;

    // drive one cycle, sample 1 ns after the capturing edge
    task automatic beat(input logic [IW-1:0] w, input bit v, input string req);
        logic [OW-1:0] exp;
        @(negedge clk);
        lane_data  = w;
        lane_valid = v;
        @(posedge clk);
        #1;
        check(smp_valid == v, "R2 valid latency", OW'(smp_valid), OW'(v));
        exp = v ? model(w) : last_beat;
        check(smp_data == exp, v ? req : "R6 hold while invalid", smp_data, exp);
        last_beat = exp;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [IW-1:0] tail_mask = '0;
        logic [IW-1:0] w;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(!smp_valid && smp_data == '0, "R1 reset state", {smp_data[OW-2:0], smp_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(!smp_valid && smp_data == '0, "R1 first clock after reset", smp_data, '0);

        // R8: derived beat width at the port
        check($bits(smp_data) == M * DPW * N && DPW == 2, "R8 output width",
              OW'($bits(smp_data)), OW'(M * DPW * N));

        // directed: zeros, ones
        beat('0, 1'b1, "R4 all zero");
        beat('1, 1'b1, "R4 all ones");

        // R3/R4/R7: walking octet across every lane position
        for (int p = 0; p < IW / 8; p++) begin
            w = '0;
            w[p*8 +: 8] = 8'hA5;
            beat(w, 1'b1, "R3 R4 R7 walking octet");
        end

        // R5: find tail bits by single-bit probing
        for (int b = 0; b < IW; b++) begin
            w = '0;
            w[b] = 1'b1;
            if (model(w) == '0) tail_mask[b] = 1'b1;
        end
        check($countones(tail_mask) == M * DPW * (NP - N), "R5 tail bit count",
              OW'($countones(tail_mask)), OW'(M * DPW * (NP - N)));
        for (int t = 0; t < 8; t++) begin
            logic [IW-1:0] base = {$urandom, $urandom};
            logic [OW-1:0] exp  = model(base);
            @(negedge clk);
            lane_data  = base ^ ({$urandom, $urandom} & tail_mask);
            lane_valid = 1'b1;
            @(posedge clk);
            #1;
            check(smp_data == exp, "R5 tail bits ignored", smp_data, exp);
            last_beat = exp;
        end

        // R6 with R2: new data while valid is low must not load
        beat({$urandom, $urandom}, 1'b1, "R3 R4 random");
        for (int t = 0; t < 6; t++) beat({$urandom, $urandom}, 1'b0, "R6");
        beat({$urandom, $urandom}, 1'b1, "R3 R4 after gap");

        // constrained random mix, valid about 3/4 of cycles
        for (int t = 0; t < 300; t++) begin
            beat({$urandom, $urandom}, ($urandom % 4) != 0, "R3 R4 R7 random");
        end

        // R1: reset in mid-run clears state again
        @(negedge clk);
        lane_valid = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(!smp_valid && smp_data == '0, "R1 reset mid-run", smp_data, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule